// File: doc/BRIEF.md
# UART Transmitter with Line-Break Control

This block serialises bytes from a small transmit FIFO onto a single TXD line as 8N1 frames. It has no baud generator of its own. A one-cycle `tick_i` pulse marks each bit-time boundary, and the line changes value only on those boundaries. An enable input allows new characters to start. A 5-bit command port accepts single-cycle commands: reset the transmitter, start a break, stop a break, drive the active-low RTS output low, and drive it high.

A break holds TXD low (spacing) until it is stopped. A start-break command does not cut into traffic. It is held pending until the FIFO has drained, including any bytes written after the command, and until the serializer is idle. When the break is stopped, the line returns high at the next tick and stays high for one full bit time before any start bit. A transmitter reset works immediately. It drops queued data, cancels any break and releases the line.

Top module: `uart_tx_brk`

## Requirements
- R1: Each character goes out as one start bit (0), eight data bits LSB first, and one stop bit (1). Each bit lasts from one tick to the next. TXD changes only in the cycle after a tick, or after a transmitter reset.
- R2: Bytes written with `wr_valid_i` are sent in write order. A new character starts only when `en_i` is high. `fifo_empty_o` is high exactly when no byte is queued. A write to a full FIFO (8 entries) is dropped.
- R3: Command 5'b00110 with `en_i` high requests a break. If the serializer is idle and the FIFO is empty, TXD goes low at the next tick. Otherwise the break waits until all queued bytes have been sent, including bytes written after the command.
- R4: Command 5'b00110 issued while `en_i` is low has no effect. It is not remembered when `en_i` later rises.
- R5: While a break is active, TXD stays low on every cycle until a stop command takes effect.
- R6: Command 5'b00111 during an active break drives TXD high at the next tick. TXD then stays high for at least one full bit time (4 cycles in the bench) before the next start bit.
- R7: Command 5'b00111 issued while a break is still pending cancels the break, so it never starts.
- R8: Command 5'b00011 empties the FIFO, aborts any character, and cancels any pending or active break. In the next cycle TXD is high, `tx_idle_o` is high and `fifo_empty_o` is high. RTS is unchanged, and a write in the same cycle is dropped.
- R9: `rts_no` resets high. Command 5'b01000 drives it low and command 5'b01001 drives it high, each from the next cycle.
- R10: `tx_idle_o` is high only when no character, break or post-break marking interval is in progress.
- R11: All other command codes (for example 5'b00000, 5'b00100, 5'b01010, 5'b11111) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| tick_i | input | 1 | One-cycle pulse at each bit-time boundary |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 5 | Command code |
| wr_valid_i | input | 1 | FIFO write strobe |
| wr_data_i | input | 8 | Byte to queue |
| txd_o | output | 1 | Serial output, idle high |
| rts_no | output | 1 | Request-to-send, active low |
| tx_idle_o | output | 1 | Serializer idle |
| fifo_empty_o | output | 1 | Transmit FIFO empty |

## Verification
The assertions check several local rules on every cycle:
- TXD moves only after a tick or a transmitter reset.
- A break begins only at a tick and only with the FIFO empty.
- An active break keeps the line low between ticks, and the marking state is left only on a tick.
- The RTS commands and the transmitter reset have their stated effect one cycle later.
- A full FIFO never overflows.

Some properties span many cycles, and only the bench's scenarios can show them: the bit order of a whole frame, a pending break waiting behind bytes written after the command, cancellation of a pending break, and the exact width of the marking gap. The bench checks these against its behavioural model and with targeted measurements.

// File: rtl/uart_tx_brk_pkg.sv
package uart_tx_brk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_BREAK, ST_MARK} tx_state_e;

  localparam logic [4:0] CMD_TX_RESET = 5'b00011;
  localparam logic [4:0] CMD_BRK_ON   = 5'b00110;
  localparam logic [4:0] CMD_BRK_OFF  = 5'b00111;
  localparam logic [4:0] CMD_RTS_LOW  = 5'b01000;
  localparam logic [4:0] CMD_RTS_HIGH = 5'b01001;
endpackage

// File: rtl/uart_tx_brk_cmd.sv
module uart_tx_brk_cmd
  import uart_tx_brk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [4:0] cmd_i,
  output logic       tx_rst_o,
  output logic       brk_on_o,
  output logic       brk_off_o,
  output logic       rts_no
);
  assign tx_rst_o  = cmd_valid_i && (cmd_i == CMD_TX_RESET);
  assign brk_on_o  = cmd_valid_i && (cmd_i == CMD_BRK_ON);
  assign brk_off_o = cmd_valid_i && (cmd_i == CMD_BRK_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      rts_no <= 1'b1;
    else if (cmd_valid_i && cmd_i == CMD_RTS_LOW)     rts_no <= 1'b0;
    else if (cmd_valid_i && cmd_i == CMD_RTS_HIGH)    rts_no <= 1'b1;
  end

  assert_rts_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_RTS_LOW) |=> !rts_no);
  assert_rts_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_RTS_HIGH) |=> rts_no);
endmodule

// File: rtl/uart_tx_brk_fifo.sv
module uart_tx_brk_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          full, do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !clr_i) |=> (count_q == CW'(DEPTH)));
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx_brk_ser.sv
module uart_tx_brk_ser
  import uart_tx_brk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          brk_on_i,
  input  logic          brk_off_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          pop_o,
  output logic          txd_o,
  output logic          idle_o
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW);

  tx_state_e     state_q, state_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          txd_q, txd_d, pend_q, pend_d, stop_q, stop_d, launch;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    txd_d   = txd_q;
    pend_d  = pend_q;
    stop_d  = stop_q;
    pop_o   = 1'b0;
    launch  = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE:  launch = 1'b1;
        ST_SHIFT: begin
          if (cnt_q == '0) launch = 1'b1;
          else begin
            sh_d  = sh_q >> 1;
            txd_d = sh_q[1];
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_BREAK: if (stop_q) begin
          state_d = ST_MARK;
          txd_d   = 1'b1;
        end
        ST_MARK:  launch = 1'b1;
        default:  launch = 1'b1;
      endcase
    end
    if (launch) begin
      if (!fifo_empty_i && en_i) begin
        sh_d    = {1'b1, fifo_data_i, 1'b0};
        txd_d   = 1'b0;
        cnt_d   = CW'(FW - 1);
        state_d = ST_SHIFT;
        pop_o   = 1'b1;
      end else if (pend_q && fifo_empty_i) begin
        state_d = ST_BREAK;
        txd_d   = 1'b0;
        pend_d  = 1'b0;
      end else begin
        state_d = ST_IDLE;
        txd_d   = 1'b1;
      end
    end
    // commands act after the tick decision, judged on the current state
    if (brk_on_i && en_i && state_q != ST_BREAK) pend_d = 1'b1;
    if (brk_off_i) begin
      if (state_q == ST_BREAK) stop_d = 1'b1;
      else                     pend_d = 1'b0;
    end
    if (state_d != ST_BREAK) stop_d = 1'b0;
    if (clr_i) begin
      state_d = ST_IDLE;
      txd_d   = 1'b1;
      pend_d  = 1'b0;
      stop_d  = 1'b0;
      cnt_d   = '0;
      pop_o   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      txd_q   <= 1'b1;
      pend_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      txd_q   <= txd_d;
      pend_q  <= pend_d;
      stop_q  <= stop_d;
    end
  end

  assign txd_o  = txd_q;
  assign idle_o = (state_q == ST_IDLE);

  assert_line_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_q) |-> $past(tick_i || clr_i));
  assert_brk_after_drain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_BREAK) |-> $past(fifo_empty_i && tick_i));
  assert_brk_held_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BREAK && !tick_i && !clr_i) |=> (state_q == ST_BREAK && !txd_q));
  assert_mark_full_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MARK && !tick_i && !clr_i) |=> (state_q == ST_MARK && txd_q));
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_brk_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          cmd_valid_i,
  input  logic [4:0]    cmd_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          txd_o,
  output logic          rts_no,
  output logic          tx_idle_o,
  output logic          fifo_empty_o
);
  logic          tx_rst, brk_on, brk_off, pop;
  logic [DW-1:0] head;

  uart_tx_brk_cmd u_cmd (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i,
    .tx_rst_o(tx_rst), .brk_on_o(brk_on), .brk_off_o(brk_off), .rts_no
  );

  uart_tx_brk_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(tx_rst), .push_i(wr_valid_i), .data_i(wr_data_i),
    .pop_i(pop), .data_o(head), .empty_o(fifo_empty_o)
  );

  uart_tx_brk_ser #(.DW(DW)) u_ser (
    .clk_i, .rst_ni, .tick_i, .en_i, .clr_i(tx_rst), .brk_on_i(brk_on),
    .brk_off_i(brk_off), .fifo_empty_i(fifo_empty_o), .fifo_data_i(head),
    .pop_o(pop), .txd_o, .idle_o(tx_idle_o)
  );

  assert_tx_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_TX_RESET) |=> (txd_o && tx_idle_o && fifo_empty_o));
endmodule

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [4:0] cmd_i = '0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       txd_o, rts_no, tx_idle_o, fifo_empty_o;

  int checks = 0, errors = 0, cycles = 0, tcnt = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  uart_tx_brk u_uart_tx_brk (
    .clk_i(clk), .rst_ni, .en_i, .tick_i, .cmd_valid_i, .cmd_i,
    .wr_valid_i, .wr_data_i, .txd_o, .rts_no, .tx_idle_o, .fifo_empty_o
  );

  // bit-time tick: one cycle in four
  always @(negedge clk) begin
    if (!rst_ni) begin tcnt <= 0; tick_i <= 1'b0; end
    else begin tcnt <= (tcnt + 1) % 4; tick_i <= (tcnt == 3); end
  end

  // behavioural reference model: 0 idle, 1 sending, 2 break, 3 marking
  bit [7:0] q[$];
  int m_state, m_old, m_frame, m_left;
  bit m_txd, m_rts, m_pend, m_stop, m_go;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete(); m_state = 0; m_txd = 1; m_rts = 1; m_pend = 0; m_stop = 0; m_left = 0;
    end else begin
      if (cmd_valid_i && cmd_i == 5'd8) m_rts = 0;
      if (cmd_valid_i && cmd_i == 5'd9) m_rts = 1;
      if (cmd_valid_i && cmd_i == 5'd3) begin
        q.delete(); m_state = 0; m_txd = 1; m_pend = 0; m_stop = 0;
      end else begin
        m_old = m_state; m_go = 0;
        if (tick_i) begin
          if (m_state == 0 || m_state == 3) m_go = 1;
          else if (m_state == 1) begin
            if (m_left == 0) m_go = 1;
            else begin m_frame = m_frame >> 1; m_txd = m_frame[0]; m_left--; end
          end else if (m_stop) begin m_state = 3; m_txd = 1; end
        end
        if (m_go) begin
          if (q.size() > 0 && en_i) begin
            m_frame = 32'h200 | (32'(q.pop_front()) << 1);
            m_txd = 0; m_left = 9; m_state = 1;
          end else if (m_pend && q.size() == 0) begin
            m_state = 2; m_txd = 0; m_pend = 0;
          end else begin
            m_state = 0; m_txd = 1;
          end
        end
        if (cmd_valid_i && cmd_i == 5'd6 && en_i && m_old != 2) m_pend = 1;
        if (cmd_valid_i && cmd_i == 5'd7) begin
          if (m_old == 2) m_stop = 1; else m_pend = 0;
        end
        if (m_state != 2) m_stop = 0;
        if (wr_valid_i && q.size() < 8) q.push_back(wr_data_i);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_ni) begin
      chk(txd_o == m_txd, {cur_req, " txd"}, int'(txd_o), int'(m_txd));
      chk(rts_no == m_rts, "R9 rts", int'(rts_no), int'(m_rts));
      chk(tx_idle_o == (m_state == 0), "R10 idle", int'(tx_idle_o), int'(m_state == 0));
      chk(fifo_empty_o == (q.size() == 0), "R2 empty", int'(fifo_empty_o), int'(q.size() == 0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [4:0] c);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_i = c;
    @(negedge clk); cmd_valid_i = 1'b0; cmd_i = '0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_valid_i = 1'b1; wr_data_i = b;
    @(negedge clk); wr_valid_i = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 2000 && !(tx_idle_o && fifo_empty_o); i++) @(negedge clk);
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (txd_o !== 1'b0 && n < 400) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, hi;
    logic [9:0] fr;
    idle_n(3);
    rst_ni = 1'b1;
    @(negedge clk);
    cur_req = "R9";
    chk(rts_no == 1'b1, "R9 reset rts", int'(rts_no), 1);
    chk(txd_o == 1'b1 && tx_idle_o && fifo_empty_o, "R10 reset state", int'(txd_o), 1);

    // R1: frame shape and bit order
    cur_req = "R1";
    wr(8'hA5);
    wait_low(n);
    for (int k = 0; k < 10; k++) begin
      idle_n(k == 0 ? 2 : 4);
      fr[k] = txd_o;
    end
    chk(fr[0] == 1'b0, "R1 start bit", int'(fr[0]), 0);
    chk(fr[8:1] == 8'hA5, "R1 data LSB first", int'(fr[8:1]), 'hA5);
    chk(fr[9] == 1'b1, "R1 stop bit", int'(fr[9]), 1);
    wait_quiet();

    // R2: order, back-to-back, enable gating
    cur_req = "R2";
    en_i = 1'b0;
    wr(8'h01); wr(8'h80); wr(8'h3C);
    idle_n(20);
    chk(tx_idle_o && txd_o && !fifo_empty_o, "R2 held while disabled", int'(tx_idle_o), 1);
    en_i = 1'b1;
    wait_quiet();
    chk(fifo_empty_o == 1'b1, "R2 drained", int'(fifo_empty_o), 1);
    for (int i = 0; i < 10; i++) wr(8'(i * 7));
    chk(fifo_empty_o == 1'b0, "R2 overfill queued", int'(fifo_empty_o), 0);
    wait_quiet();

    // R3/R5/R6: break from idle, hold, stop, marking gap
    cur_req = "R3";
    cmd(5'b00110);
    idle_n(9);
    chk(txd_o == 1'b0 && !tx_idle_o, "R3 break within two bit times", int'(txd_o), 0);
    cur_req = "R5";
    idle_n(40);
    chk(txd_o == 1'b0, "R5 break held", int'(txd_o), 0);
    cur_req = "R6";
    cmd(5'b00111);
    wr(8'h00);
    for (int i = 0; i < 20 && txd_o == 1'b0; i++) @(negedge clk);
    hi = 0;
    while (txd_o == 1'b1 && hi < 100) begin @(negedge clk); hi++; end
    chk(hi >= 4, "R6 marking gap", hi, 4);
    wait_quiet();
    chk(txd_o == 1'b1, "R6 line high after", int'(txd_o), 1);

    // R3: break deferred behind queued and later bytes
    cur_req = "R3";
    wr(8'h11); wr(8'h22);
    cmd(5'b00110);
    wr(8'h33);
    idle_n(30);
    chk(fifo_empty_o == 1'b0 || txd_o == 1'b1 || !tx_idle_o, "R3 still sending", int'(txd_o), 1);
    idle_n(140);
    chk(txd_o == 1'b0 && fifo_empty_o && !tx_idle_o, "R3 break after drain", int'(txd_o), 0);
    cmd(5'b00111);
    wait_quiet();

    // R4: break ignored while disabled
    cur_req = "R4";
    en_i = 1'b0;
    cmd(5'b00110);
    idle_n(12);
    chk(txd_o == 1'b1 && tx_idle_o, "R4 disabled no break", int'(txd_o), 1);
    en_i = 1'b1;
    idle_n(12);
    chk(txd_o == 1'b1 && tx_idle_o, "R4 not remembered", int'(txd_o), 1);

    // R7: stop cancels pending break
    cur_req = "R7";
    wr(8'h5A); wr(8'hC3);
    cmd(5'b00110);
    cmd(5'b00111);
    wait_quiet();
    idle_n(12);
    chk(txd_o == 1'b1 && tx_idle_o, "R7 pending cancelled", int'(txd_o), 1);

    // R8: reset mid-character and mid-break, RTS untouched
    cur_req = "R8";
    cmd(5'b01000);
    wr(8'hF0); wr(8'h0F); wr(8'hAA);
    idle_n(10);
    cmd(5'b00011);
    chk(txd_o && tx_idle_o && fifo_empty_o, "R8 reset mid char", int'(txd_o), 1);
    chk(rts_no == 1'b0, "R8 rts kept", int'(rts_no), 0);
    cmd(5'b00110);
    wait_low(n);
    cmd(5'b00011);
    chk(txd_o == 1'b1 && tx_idle_o, "R8 reset ends break", int'(txd_o), 1);
    idle_n(12);
    chk(txd_o == 1'b1, "R8 break stays cancelled", int'(txd_o), 1);

    // R9: RTS commands
    cur_req = "R9";
    cmd(5'b01001);
    chk(rts_no == 1'b1, "R9 rts high", int'(rts_no), 1);
    cmd(5'b01000);
    chk(rts_no == 1'b0, "R9 rts low", int'(rts_no), 0);

    // R11: unused codes
    cur_req = "R11";
    cmd(5'b00000); cmd(5'b00100); cmd(5'b01010); cmd(5'b11111);
    idle_n(8);
    chk(txd_o && tx_idle_o && fifo_empty_o && !rts_no, "R11 no effect idle", int'(txd_o), 1);
    cmd(5'b00110);
    wait_low(n);
    cmd(5'b00101); cmd(5'b01111);
    idle_n(8);
    chk(txd_o == 1'b0, "R11 no effect in break", int'(txd_o), 0);
    cmd(5'b00111);
    wait_quiet();

    idle_n(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule